// File: doc/BRIEF.md
# Single-Wire Power Sequencing Controller

This block is the standby controller of a board. It owns the shutdown outputs of the board's supply rails and shares one open status net with a host processor. The block drives that net only weakly, through a series resistor modelled as a level output. A host can pull the net low with a stronger drive. The block reads the resolved level back through a sense input. Power-down requests, acknowledges and the current power state all travel over this one net as timed pulses and static levels.

In normal mode the block holds the net high and the rails powered. A debounced release of the pushbutton makes the block send a timed low pulse, which asks the host to save its context. When the host then holds the net low for long enough, the block shuts every rail off and drives the net low itself. A later button release restores the rails. The weak low drive stays in place, so the host can tell a warm restart from a cold one, until software pulses a clear input. All timers count a microsecond tick, which is divided from the clock by `CLK_PER_US`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the weak net drive `net_drive_o` is 1 and every bit of `rail_shdn_o` is 0.
- R2: Pressing the button (`btn_raw_i` = 1) causes no action. Only a release after at least `DEBOUNCE_US` microseconds of stable press is acted on. A press shorter than `DEBOUNCE_US` - 1 microseconds is ignored.
- R3: In normal mode, a qualified button release drives `net_drive_o` to 0 for exactly `PULSE_US` × `CLK_PER_US` clock cycles, after which it returns to 1. The rails stay powered throughout.
- R4: In normal mode with the net weakly driven high, if the sensed net stays low for at least `ACK_QUAL_US` + 1 microseconds, all bits of `rail_shdn_o` are set to 1 together. This holds whether or not a button request came first.
- R5: While any rail is shut down, `net_drive_o` is 0.
- R6: A low on the sensed net lasting at most `ACK_QUAL_US` - 1 microseconds is not taken as an acknowledge. The block's own request pulse is never taken as an acknowledge either.
- R7: In low power mode, a qualified button release clears all bits of `rail_shdn_o` to 0, while `net_drive_o` stays 0.
- R8: After a restart, `net_drive_o` stays 0 until `warm_clr_i` is high on a clock edge. It returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw_i | input | 1 | Raw pushbutton, 1 = pressed |
| net_sense_i | input | 1 | Resolved level of the shared status net |
| warm_clr_i | input | 1 | Software pulse that ends the warm-start indication |
| net_drive_o | output | 1 | Weak level driven onto the status net |
| rail_shdn_o | output | N_RAILS | Rail shutdown outputs, 1 = rail off |

## Verification
The entry check for shutdown assumes the host keeps the net low until the shutdown appears. It therefore looks at the cycle before the rise and expects the net sensed low while the weak drive was high. The bench model does exactly that: it resolves the net as the weak drive unless a host pull-low is active, and it holds the pull until the rails switch off. The button and the clear input change only between clock edges. Presses are either held well past the debounce time or kept clearly shorter than it, so no stimulus falls on a tick boundary where the outcome would be ambiguous.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_REQ    = 2'd1,
    ST_LOW    = 2'd2,
    ST_WARM   = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [W-1:0] LAST = W'(CLK_PER_US - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (restart_i || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int DEBOUNCE_US = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic btn_raw_i,
  output logic release_o
);
  localparam int CW = $clog2(DEBOUNCE_US + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_US - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   btn_s;
  logic                   stable_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   differ, flip;
  logic                   rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw_i};
  end
  assign btn_s = sync_q[SYNC_STAGES-1];

  assign differ = (btn_s != stable_q);
  assign flip   = differ && tick_i && (cnt_q == LAST);

  always_comb begin
    if (!differ || flip) cnt_d = '0;
    else if (tick_i)     cnt_d = cnt_q + CW'(1);
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (flip) stable_q <= btn_s;
      rel_q <= flip && stable_q;
    end
  end

  assign release_o = rel_q;
endmodule

// File: rtl/ack_qualifier.sv
module ack_qualifier #(
  parameter int ACK_QUAL_US = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  input  logic net_sense_i,
  output logic ack_o
);
  localparam int CW = $clog2(ACK_QUAL_US + 1);
  localparam logic [CW-1:0] FULL = CW'(ACK_QUAL_US);

  logic [SYNC_STAGES-1:0] sense_q;
  logic [SYNC_STAGES-1:0] arm_q;
  logic                   sense_s, enable;
  logic [CW-1:0]          cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '1;
      arm_q   <= '0;
    end else begin
      sense_q <= {sense_q[SYNC_STAGES-2:0], net_sense_i};
      arm_q   <= {arm_q[SYNC_STAGES-2:0], arm_i};
    end
  end

  assign sense_s = sense_q[SYNC_STAGES-1];
  // Armed only once the sensed level has had time to follow the weak drive.
  assign enable  = arm_i && (&arm_q);

  always_comb begin
    if (!enable || sense_s)           cnt_d = '0;
    else if (tick_i && cnt_q != FULL) cnt_d = cnt_q + CW'(1);
    else                              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ack_o = enable && (cnt_q == FULL);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int PULSE_US = 10,
  parameter int N_RAILS  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               release_i,
  input  logic               ack_i,
  input  logic               warm_clr_i,
  output pwr_state_e         state_o,
  output logic               tick_restart_o,
  output logic               net_drive_o,
  output logic [N_RAILS-1:0] rail_shdn_o
);
  localparam int PW = (PULSE_US > 1) ? $clog2(PULSE_US) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PULSE_US - 1);

  pwr_state_e         state_q, state_d;
  logic [PW-1:0]      pcnt_q, pcnt_d;
  logic               pulse_done;
  logic               state_chg;
  logic               drive_q;
  logic [N_RAILS-1:0] shdn_q;

  assign pulse_done = tick_i && (pcnt_q == PLAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (ack_i)          state_d = ST_LOW;
        else if (release_i) state_d = ST_REQ;
      end
      ST_REQ:  if (pulse_done) state_d = ST_NORMAL;
      ST_LOW:  if (release_i)  state_d = ST_WARM;
      ST_WARM: if (warm_clr_i) state_d = ST_NORMAL;
      default: state_d = ST_NORMAL;
    endcase
  end

  always_comb begin
    if (state_q != ST_REQ) pcnt_d = '0;
    else if (tick_i)       pcnt_d = pcnt_q + PW'(1);
    else                   pcnt_d = pcnt_q;
  end

  assign state_chg      = (state_d != state_q);
  assign tick_restart_o = (state_q == ST_NORMAL) && (state_d == ST_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      pcnt_q  <= '0;
      drive_q <= 1'b1;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      if (state_chg) drive_q <= (state_d == ST_NORMAL);
    end
  end

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shdn_q[g] <= 1'b0;
      else if (state_chg) shdn_q[g] <= (state_d == ST_LOW);
    end
  end

  assign state_o     = state_q;
  assign net_drive_o = drive_q;
  assign rail_shdn_o = shdn_q;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int DEBOUNCE_US = 5000,
  parameter int PULSE_US    = 10,
  parameter int ACK_QUAL_US = 2,
  parameter int N_RAILS     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_raw_i,
  input  logic               net_sense_i,
  input  logic               warm_clr_i,
  output logic               net_drive_o,
  output logic [N_RAILS-1:0] rail_shdn_o
);
  logic       tick_w, tick_restart_w, release_w, ack_w, arm_w;
  pwr_state_e state_w;

  us_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tick_restart_w),
    .tick_o    (tick_w)
  );

  btn_conditioner #(.DEBOUNCE_US(DEBOUNCE_US), .SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_w),
    .btn_raw_i (btn_raw_i),
    .release_o (release_w)
  );

  assign arm_w = (state_w == ST_NORMAL) && net_drive_o;

  ack_qualifier #(.ACK_QUAL_US(ACK_QUAL_US), .SYNC_STAGES(SYNC_STAGES)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_w),
    .arm_i       (arm_w),
    .net_sense_i (net_sense_i),
    .ack_o       (ack_w)
  );

  pwr_seq_fsm #(.PULSE_US(PULSE_US), .N_RAILS(N_RAILS)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick_w),
    .release_i      (release_w),
    .ack_i          (ack_w),
    .warm_clr_i     (warm_clr_i),
    .state_o        (state_w),
    .tick_restart_o (tick_restart_w),
    .net_drive_o    (net_drive_o),
    .rail_shdn_o    (rail_shdn_o)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int PULSE_US   = 10,
  parameter int N_RAILS    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               net_sense_i,
  input logic               warm_clr_i,
  input logic               net_drive_o,
  input logic [N_RAILS-1:0] rail_shdn_o,
  input pwr_state_e         state_w
);
  localparam int PULSE_CYC = PULSE_US * CLK_PER_US;
  localparam int RW = $clog2(PULSE_CYC + 2);

  logic [RW-1:0] req_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        req_cnt_q <= '0;
    else if (state_w != ST_REQ)                        req_cnt_q <= '0;
    else if (req_cnt_q != RW'(PULSE_CYC + 1))          req_cnt_q <= req_cnt_q + RW'(1);
  end

  AST_RAILS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_shdn_o == '0) || (rail_shdn_o == '1)); // R4

  AST_ACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_shdn_o[0]) |-> ($past(net_drive_o) && !$past(net_sense_i))); // R4

  AST_SHDN_WEAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|rail_shdn_o) |-> !net_drive_o); // R5

  AST_RESTART_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_shdn_o[0]) |-> !net_drive_o); // R7

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt_q <= RW'(PULSE_CYC)); // R3

  AST_WARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_WARM && !warm_clr_i) |=> (state_w == ST_WARM && !net_drive_o)); // R8
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
  .CLK_PER_US (CLK_PER_US),
  .PULSE_US   (PULSE_US),
  .N_RAILS    (N_RAILS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .net_sense_i (net_sense_i),
  .warm_clr_i  (warm_clr_i),
  .net_drive_o (net_drive_o),
  .rail_shdn_o (rail_shdn_o),
  .state_w     (state_w)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int C  = 4;
  localparam int DB = 3;
  localparam int P  = 10;
  localparam int Q  = 2;
  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          btn;
  logic          host_pull;
  logic          warm_clr;
  logic          net_drive;
  logic [NR-1:0] shdn;
  logic          net_sense;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign net_sense = host_pull ? 1'b0 : net_drive;

  pwr_seq_ctrl #(
    .CLK_PER_US(C), .DEBOUNCE_US(DB), .PULSE_US(P), .ACK_QUAL_US(Q), .N_RAILS(NR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .btn_raw_i(btn), .net_sense_i(net_sense),
    .warm_clr_i(warm_clr), .net_drive_o(net_drive), .rail_shdn_o(shdn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(net_drive == 1'b1, "R1 drive", net_drive, 1);
    chk(shdn == '0, "R1 shdn", shdn, 0);
  endtask

  task automatic t_glitch();
    int lows = 0;
    btn = 1'b1; cyc(C);
    btn = 1'b0;
    for (int i = 0; i < 200; i++) begin
      cyc(1);
      if (!net_drive) lows++;
    end
    chk(lows == 0, "R2 short press ignored", lows, 0);
  endtask

  task automatic t_request();
    int lows = 0, wait_c = 0, shdn_seen = 0;
    btn = 1'b1; cyc(100);
    chk(net_drive == 1'b1, "R2 press not acted on", net_drive, 1);
    btn = 1'b0;
    while (net_drive && wait_c < 200) begin cyc(1); wait_c++; end
    chk(!net_drive, "R2 release starts request", net_drive, 0);
    while (!net_drive && lows < 500) begin
      if (shdn != '0) shdn_seen++;
      cyc(1); lows++;
    end
    chk(lows == P * C, "R3 pulse width", lows, P * C);
    chk(shdn_seen == 0, "R3 rails powered during pulse", shdn_seen, 0);
    cyc(100);
    chk(shdn == '0, "R6 own pulse not an ack", shdn, 0);
    chk(net_drive == 1'b1, "R3 drive back high", net_drive, 1);
  endtask

  task automatic t_short_pull();
    host_pull = 1'b1; cyc(C);
    host_pull = 1'b0; cyc(100);
    chk(shdn == '0, "R6 short low ignored", shdn, 0);
    chk(net_drive == 1'b1, "R6 drive stays high", net_drive, 1);
  endtask

  task automatic t_ack();
    int wait_c = 0;
    host_pull = 1'b1;
    while (shdn == '0 && wait_c < 200) begin cyc(1); wait_c++; end
    chk(shdn == '1, "R4 all rails shut without button", shdn, (1 << NR) - 1);
    chk(wait_c >= (Q - 1) * C, "R4 qualification time", wait_c, (Q - 1) * C);
    chk(net_drive == 1'b0, "R5 drive low in low power", net_drive, 0);
    host_pull = 1'b0; cyc(50);
    chk(shdn == '1, "R5 stays shut", shdn, (1 << NR) - 1);
    chk(net_drive == 1'b0, "R5 drive still low", net_drive, 0);
  endtask

  task automatic t_restart();
    btn = 1'b1; cyc(100);
    chk(shdn == '1, "R7 press does not restart", shdn, (1 << NR) - 1);
    btn = 1'b0; cyc(60);
    chk(shdn == '0, "R7 rails restored", shdn, 0);
    chk(net_drive == 1'b0, "R7 drive stays low", net_drive, 0);
    cyc(300);
    chk(net_drive == 1'b0, "R8 warm indication held", net_drive, 0);
    warm_clr = 1'b1; cyc(1);
    warm_clr = 1'b0; cyc(2);
    chk(net_drive == 1'b1, "R8 clear returns drive high", net_drive, 1);
    chk(shdn == '0, "R8 rails remain on", shdn, 0);
  endtask

  initial begin
    btn = 1'b0; host_pull = 1'b0; warm_clr = 1'b0; rst_n = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_glitch();
    t_request();
    t_short_pull();
    t_ack();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule